// File: doc/BRIEF.md
# Edge Port Interrupt Unit

This block turns a small group of external pins into interrupt requests for a
system interrupt controller. Each pin passes through a two-flop synchroniser.
Software then chooses, line by line, whether the line asserts its request while
the pin is held low or reacts to a rising edge, a falling edge or either edge.
In the edge modes a detected transition sets a sticky flag. The flag keeps the
request asserted until software clears it by writing a one to the flag
register.

A line can only raise a request when two conditions hold: its direction bit
marks it as an input, and its enable bit is set. Line 0 exists in the register
layout but is reserved and stays silent. The registers sit behind a simple port
with a write strobe, an address and a combinational read path. The unit drives
one request wire per line toward the interrupt controller.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset the sense, direction, enable and flag registers read zero, and every request output is low.
- R2: The register addresses are 0 for sense, 1 for direction, 2 for enable, 3 for flags and 4 for synchronised pin levels (read-only). In the sense register, line n uses bits [2n+1:2n]. The direction, enable and flag registers use bit n for line n. Unused addresses read zero.
- R3: In sense mode 00 (level), request n is high while the synchronised pin n is low, enable n is 1 and direction n is 0. The request rises two clock edges after the pin falls.
- R4: A line with enable 0 never requests. A line with direction 1 neither requests nor sets its flag.
- R5: Sense mode 01 sets flag n on a rising pin edge, 10 on a falling edge and 11 on either edge. The flag and the request (flag AND enable) appear at the third clock edge after the pin change.
- R6: An edge-mode flag stays set after the pin returns to its former level.
- R7: Writing to address 3 clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R8: When an edge arrives in the same cycle as a clearing write to that line's flag, the flag stays set.
- R9: Line 0 never sets its flag bit and never drives its request, in any mode.
- R10: Level mode never sets a flag. A clearing write in level mode leaves the request unchanged.
- R11: Address 4 returns the pin levels after the two-flop synchroniser, which is two clock edges after the pins change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous external pins, bit n is line n |
| reg_wr | input | 1 | Register write strobe, taken at the rising clock edge |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq_o | output | 8 | Per-line interrupt request, bit 0 always low |

## Verification
The bench uses the default build: eight line positions (the reserved line 0 plus seven active lines) and a two-stage synchroniser. With this build a 16-bit sense register packs all eight 2-bit modes. Every sense encoding can be exercised on one line while the other lines show the effects of enable, direction and the reserved position. Because the synchroniser is two stages deep, the exact latency of level and edge requests can be checked edge by edge. The same depth lets the bench place a clearing write exactly on the cycle in which an edge is detected.

// File: rtl/epi_pkg.sv
package epi_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] ADDR_SENSE = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_DIR   = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_EN    = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_FLAG  = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_PIN   = 3'd4;

  // True when the transition prev -> cur matches the selected edge sense.
  function automatic logic edge_match(sense_e mode, logic cur, logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      SENSE_RISE: edge_match = rise;
      SENSE_FALL: edge_match = fall;
      SENSE_BOTH: edge_match = rise | fall;
      default:    edge_match = 1'b0;
    endcase
  endfunction

  // Level request: active-low pin in level mode.
  function automatic logic level_active(sense_e mode, logic cur);
    level_active = (mode == SENSE_LEVEL) && !cur;
  endfunction

endpackage

// File: rtl/epi_sync.sv
module epi_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else begin
      stg[0] <= pin_i;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign sync_o = stg[STAGES-1];
  assign prev_o = stg[STAGES];
endmodule

// File: rtl/epi_regs.sv
module epi_regs
  import epi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int DW = 2 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NUM_LINES-1:0] flag_i,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [DW-1:0]        rdata,
  output logic [DW-1:0]        sense_q,
  output logic [NUM_LINES-1:0] dir_q,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] clr_mask
);
  localparam int PAD = DW - NUM_LINES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      dir_q   <= '0;
      en_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_SENSE: sense_q <= wdata;
        ADDR_DIR:   dir_q   <= wdata[NUM_LINES-1:0];
        ADDR_EN:    en_q    <= wdata[NUM_LINES-1:0];
        default:    ;
      endcase
    end
  end

  assign clr_mask = (wr_en && addr == ADDR_FLAG) ? wdata[NUM_LINES-1:0] : '0;

  always_comb begin
    case (addr)
      ADDR_SENSE: rdata = sense_q;
      ADDR_DIR:   rdata = {{PAD{1'b0}}, dir_q};
      ADDR_EN:    rdata = {{PAD{1'b0}}, en_q};
      ADDR_FLAG:  rdata = {{PAD{1'b0}}, flag_i};
      ADDR_PIN:   rdata = {{PAD{1'b0}}, pin_i};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/epi_line.sv
module epi_line
  import epi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sense,
  input  logic       dir_out,
  input  logic       enable,
  input  logic       clr,
  input  logic       cur,
  input  logic       prev,
  output logic       flag_o,
  output logic       hit_o,
  output logic       irq_o
);
  sense_e mode;
  logic   is_input;

  assign mode     = sense_e'(sense);
  assign is_input = ~dir_out;
  assign hit_o    = is_input & edge_match(mode, cur, prev);

  // A fresh edge wins over a clearing write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= (flag_o & ~clr) | hit_o;
  end

  assign irq_o = enable & is_input &
                 ((mode == SENSE_LEVEL) ? level_active(mode, cur) : flag_o);
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import epi_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_LINES-1:0]     pin_i,
  input  logic                     reg_wr,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [2*NUM_LINES-1:0]   reg_wdata,
  output logic [2*NUM_LINES-1:0]   reg_rdata,
  output logic [NUM_LINES-1:0]     irq_o
);
  localparam int DW = 2 * NUM_LINES;

  logic [NUM_LINES-1:0] pin_sync, pin_prev;
  logic [DW-1:0]        sense_q;
  logic [NUM_LINES-1:0] dir_q, en_q, clr_mask;
  logic [NUM_LINES-1:0] flag_q, edge_hit, level_mask;

  epi_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .sync_o(pin_sync), .prev_o(pin_prev)
  );

  epi_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .flag_i(flag_q), .pin_i(pin_sync),
    .rdata(reg_rdata), .sense_q(sense_q), .dir_q(dir_q),
    .en_q(en_q), .clr_mask(clr_mask)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign level_mask[i] = (sense_q[2*i +: 2] == SENSE_LEVEL);
    if (i == 0) begin : g_reserved
      assign flag_q[i]   = 1'b0;
      assign edge_hit[i] = 1'b0;
      assign irq_o[i]    = 1'b0;
    end else begin : g_active
      epi_line u_line (
        .clk(clk), .rst_n(rst_n),
        .sense(sense_q[2*i +: 2]), .dir_out(dir_q[i]), .enable(en_q[i]),
        .clr(clr_mask[i]), .cur(pin_sync[i]), .prev(pin_prev[i]),
        .flag_o(flag_q[i]), .hit_o(edge_hit[i]), .irq_o(irq_o[i])
      );
    end
  end
endmodule

// File: rtl/epi_checker.sv
module epi_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_o,
  input logic [N-1:0] flag,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] clr_mask,
  input logic [N-1:0] en_q,
  input logic [N-1:0] dir_q,
  input logic [N-1:0] level_mask
);
  a_r9_line0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[0] == 1'b0) && (flag[0] == 1'b0));

  a_r4_gated_request: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~(en_q & ~dir_q)) == '0);

  a_r5_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((flag & $past(edge_hit)) == $past(edge_hit)));

  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & clr_mask) != '0) |=> ((flag & $past(edge_hit & clr_mask)) != '0));

  a_r7_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag) & ~flag & ~$past(clr_mask)) == '0));

  a_r10_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag) & $past(level_mask)) == '0));
endmodule

bind edge_irq_unit epi_checker #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .flag(flag_q),
  .edge_hit(edge_hit), .clr_mask(clr_mask), .en_q(en_q),
  .dir_q(dir_q), .level_mask(level_mask)
);

// File: tb/test_edge_irq_unit.sv
module test_edge_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int DW = 2 * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pin = '1;
  logic          wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NL-1:0] irq;

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;

  edge_irq_unit i_edge_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {sense[1:0], pin_from, pin_to, exp_flag, exp_irq} for line 3
  localparam logic [5:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(3);

    // R1 reset state
    reg_read(3'd0, r); check("R1 sense", r, 0);
    reg_read(3'd1, r); check("R1 dir", r, 0);
    reg_read(3'd2, r); check("R1 enable", r, 0);
    reg_read(3'd3, r); check("R1 flag", r, 0);
    check("R1 irq", irq, 0);

    // R2 register layout and readback
    reg_write(3'd0, 16'h0C00);          // line 5 bits [11:10] = both
    reg_read(3'd0, r); check("R2 sense line5 field", r[11:10], 2'b11);
    reg_write(3'd1, 16'h00A5);
    reg_read(3'd1, r); check("R2 dir", r, 16'h00A5);
    reg_write(3'd2, 16'h005A);
    reg_read(3'd2, r); check("R2 enable", r, 16'h005A);
    reg_read(3'd6, r); check("R2 unused address", r, 0);
    reg_write(3'd0, 16'h0000);
    reg_write(3'd1, 16'h0000);
    reg_write(3'd2, 16'h0000);

    // R11 synchroniser readback
    @(negedge clk); pin = 8'hA5;
    @(negedge clk); addr = 3'd4; #1 check("R11 one edge old", rdata, 16'h00FF);
    @(negedge clk); #1 check("R11 two edges new", rdata, 16'h00A5);
    pin = '1; settle(4);

    // Table walk on line 3: R3 R5 R6 R10
    reg_write(3'd2, 16'h0008);
    for (int v = 0; v < 8; v++) begin
      reg_write(3'd0, DW'(VEC[v][5:4]) << 6);
      pin[3] = VEC[v][3];
      settle(5);
      reg_write(3'd3, 16'h00FF);
      pin[3] = VEC[v][2];
      settle(5);
      reg_read(3'd3, r);
      check($sformatf("R5/R6/R10 vec%0d flag", v), r[3], VEC[v][1]);
      check($sformatf("R3/R5 vec%0d irq", v), irq[3], VEC[v][0]);
    end

    // R10 clear-write in level mode is harmless (line 3 level, pin low)
    reg_write(3'd0, 16'h0000);
    pin[3] = 1'b0; settle(4);
    reg_write(3'd3, 16'h00FF);
    settle(1);
    check("R10 level irq after clear", irq[3], 1);
    pin = '1; settle(4);

    // R3 level latency on line 5
    reg_write(3'd2, 16'h0020);
    @(negedge clk); pin[5] = 1'b0;
    @(negedge clk); check("R3 level after one edge", irq[5], 0);
    @(negedge clk); check("R3 level after two edges", irq[5], 1);
    pin[5] = 1'b1; settle(4);

    // R5 edge latency on line 4, rising
    reg_write(3'd0, 16'h0100);
    reg_write(3'd2, 16'h0010);
    pin[4] = 1'b0; settle(4);
    reg_write(3'd3, 16'h00FF);
    @(negedge clk); pin[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R5 edge after two edges", irq[4], 0);
    @(negedge clk); check("R5 edge after three edges", irq[4], 1);

    // R4 enable off: flag sets, no request
    reg_write(3'd2, 16'h0000);
    pin[4] = 1'b0; settle(4);
    reg_write(3'd3, 16'h00FF);
    pin[4] = 1'b1; settle(5);
    reg_read(3'd3, r); check("R4 disabled flag still set", r[4], 1);
    check("R4 disabled no irq", irq[4], 0);

    // R4 output direction: no flag, no request
    reg_write(3'd2, 16'h0010);
    reg_write(3'd1, 16'h0010);
    reg_write(3'd3, 16'h00FF);
    pin[4] = 1'b0; settle(4);
    pin[4] = 1'b1; settle(5);
    reg_read(3'd3, r); check("R4 output line flag", r[4], 0);
    check("R4 output line irq", irq[4], 0);
    reg_write(3'd1, 16'h0000);

    // R7 write-one-to-clear on lines 2 and 6 (both rising)
    reg_write(3'd0, 16'h1010);
    reg_write(3'd2, 16'h0044);
    pin[2] = 1'b0; pin[6] = 1'b0; settle(4);
    reg_write(3'd3, 16'h00FF);
    pin[2] = 1'b1; pin[6] = 1'b1; settle(5);
    reg_write(3'd3, 16'h0000);
    reg_read(3'd3, r); check("R7 zero write keeps flags", r[7:0], 8'h44);
    reg_write(3'd3, 16'h0004);
    reg_read(3'd3, r); check("R7 one clears only line 2", r[7:0], 8'h40);
    check("R7 irq follows", irq & 8'h44, 8'h40);

    // R8 edge coinciding with clear on line 2; line 6 clears normally
    pin[2] = 1'b0; settle(4);
    @(negedge clk); pin[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    reg_write(3'd3, 16'h00FF);
    reg_read(3'd3, r); check("R8 edge wins over clear", r[7:0], 8'h04);

    // R9 line 0 reserved
    reg_write(3'd0, 16'h0003);
    reg_write(3'd2, 16'h0001);
    reg_write(3'd3, 16'h00FF);
    pin[0] = 1'b0; settle(4);
    pin[0] = 1'b1; settle(4);
    reg_read(3'd3, r); check("R9 line0 flag", r[0], 0);
    check("R9 line0 irq edge mode", irq[0], 0);
    reg_write(3'd0, 16'h0000);
    pin[0] = 1'b0; settle(4);
    check("R9 line0 irq level mode", irq[0], 0);

    done = 1;
    summary();
    $finish;
  end
endmodule